// File: doc/BRIEF.md
# Four-Pin Bidirectional I/O Port with Direction Control

This block is a small general-purpose I/O port attached to an 8-bit register bus. It has two registers. A one-bit address selects between them. The data register holds an output latch that feeds the pad drivers. The direction register sets, pin by pin, whether the pad driver is enabled or held in high impedance. Pins 0 to 2 are fully bidirectional. Pin 3 can only be an input. Its direction bit is fixed at 1, and it has no output signals at all.

A read of the data register does not return the latch. It returns the pin levels after a two-stage synchronizer. Two inputs can force a pin to read 0. Each pin has an analog-select input, and asserting it makes that pin read 0. Pin 3 also reads 0 while the master-clear enable input is high.

Single-bit set and clear are done by the bus master as read-modify-write. The master reads the pin levels, changes one bit, and writes the whole byte back into the latch. Bits 7 to 4 of both registers are unimplemented.

Top module: `gpio4_port`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, direction bits 2..0 become 1. After reset, the direction register reads 8'h0F, `pad_oe` is 3'b000 and `pad_dout` is 3'b000.
- R2: A write with `bus_sel`=1 (direction) stores `bus_wdata[2:0]` at that edge. Afterwards `pad_oe[i]` equals the inverse of direction bit i, and the direction read returns {4'b0000, 1'b1, dir[2:0]}.
- R3: A write with `bus_sel`=0 (data) stores `bus_wdata[2:0]` into the output latch at that edge, and `pad_dout` shows it from then on. Data bits 7..3 of the write have no effect.
- R4: A read with `bus_sel`=0 returns {4'b0000, level[3:0]}. Here `level` is `pin_in` delayed by exactly two clock edges; it is not the latch.
- R5: Any pin i with `analog_sel[i]`=1 reads as 0 through the data register, whatever its level. It has no effect on that pin's direction or driver.
- R6: While `mclr_en`=1, bit 3 of the data read is 0.
- R7: A read-modify-write bit set or clear stores the read pin levels of bits 2..0, with only the addressed bit changed, into the latch.
- R8: Pin 3 is never driven. Writing 0 to direction bit 3 still reads back as 1, and `pad_oe` stays 3 bits wide, covering only pins 0..2.
- R9: A data write leaves the direction register unchanged. A direction write leaves the latch unchanged. With `bus_we`=0, neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the selected register |
| pin_in | input | 4 | Pad input levels, asynchronous |
| analog_sel | input | 4 | Per-pin analog assignment; forces the read value to 0 |
| mclr_en | input | 1 | Pin 3 used as master clear; forces its read value to 0 |
| pad_dout | output | 3 | Output latch to the pad drivers of pins 0..2 |
| pad_oe | output | 3 | Driver enables for pins 0..2, active high |

## Verification
The hardest case to set up is a read-modify-write where the pin levels and the latch disagree. Only then does it show that the latch takes the pin levels and not its own old contents. To get there, the bench first loads the latch with one pattern. It then drives a different pattern on `pin_in` and lets it pass through the two synchronizer stages. Only after that does it perform the bit set or clear. The bench also samples a read one edge after a pin change, to show that the old level is still visible at that point.

// File: rtl/gpio4_pkg.sv
// Package: shared constants and types of the four-pin I/O port.
// Assumes: one address bit selects between the two registers.
package gpio4_pkg;
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } gpio_sel_e;

    localparam int unsigned BUS_W = 8;
endpackage

// File: rtl/gpio4_sync.sv
// Module: gpio4_sync
// Multi-stage synchronizer for the asynchronous pad levels.
// Assumes: each pin is independent; no cross-bit coherence is required.
module gpio4_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pad levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio4_regs.sv
// Module: gpio4_regs
// Holds the output latch and the direction bits of the drivable pins.
// Assumes: the input-only pin has no storage; writes to absent bits are dropped.
module gpio4_regs #(
    parameter int unsigned OUT_W = 3,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [BUS_W-1:0] wdata,
    output logic [OUT_W-1:0] latch_q,
    output logic [OUT_W-1:0] dir_q
);
    // Output latch: loaded by data-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (wr_data) latch_q <= wdata[OUT_W-1:0];
    end

    // Direction bits: all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata[OUT_W-1:0];
    end

    assert_latch_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(latch_q));
    assert_dir_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio4_readmux.sv
// Module: gpio4_readmux
// Forms the read byte: masked pin levels or direction view.
// Assumes: the highest pin is input-only and may serve as master clear.
module gpio4_readmux #(
    parameter int unsigned PORT_W = 4,
    parameter int unsigned BUS_W  = 8,
    localparam int unsigned OUT_W = PORT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_dir,
    input  logic [PORT_W-1:0] level,
    input  logic [PORT_W-1:0] analog_sel,
    input  logic              mclr_en,
    input  logic [OUT_W-1:0]  dir_q,
    output logic [BUS_W-1:0]  rdata
);
    logic [PORT_W-1:0] visible;

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_mask
            if (i == PORT_W - 1) begin : g_top
                // Input-only pin: hidden by analog use or master clear.
                assign visible[i] = level[i] & ~analog_sel[i] & ~mclr_en;
            end else begin : g_io
                // Bidirectional pin: hidden by analog use.
                assign visible[i] = level[i] & ~analog_sel[i];
            end
        end
    endgenerate

    // Select the register view and zero the unimplemented bits.
    always_comb begin
        rdata = '0;
        if (sel_dir) rdata[PORT_W-1:0] = {1'b1, dir_q};
        else         rdata[PORT_W-1:0] = visible;
    end

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W-1:PORT_W] == '0);
    assert_dir3_reads1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_dir |-> rdata[PORT_W-1]);
    assert_mclr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_dir && mclr_en) |-> !rdata[PORT_W-1]);
    assert_analog_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_dir |-> ((rdata[PORT_W-1:0] & analog_sel) == '0));
endmodule

// File: rtl/gpio4_port.sv
// Module: gpio4_port (top)
// Four-pin I/O port on an 8-bit bus, with a data latch and direction control.
// Assumes: a one-bit address; pin 3 is input-only; pads are external.
module gpio4_port
    import gpio4_pkg::*;
#(
    parameter int unsigned PORT_W      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned OUT_W      = PORT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] analog_sel,
    input  logic              mclr_en,
    output logic [OUT_W-1:0]  pad_dout,
    output logic [OUT_W-1:0]  pad_oe
);
    gpio_sel_e         sel;
    logic [PORT_W-1:0] level;
    logic [OUT_W-1:0]  latch_q;
    logic [OUT_W-1:0]  dir_q;

    assign sel = gpio_sel_e'(bus_sel);

    gpio4_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(level)
    );

    gpio4_regs #(.OUT_W(OUT_W), .BUS_W(BUS_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_data(bus_we && sel == SEL_DATA),
        .wr_dir(bus_we && sel == SEL_DIR),
        .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio4_readmux #(.PORT_W(PORT_W), .BUS_W(BUS_W)) rmux_i (
        .clk(clk), .rst_n(rst_n), .sel_dir(sel == SEL_DIR),
        .level(level), .analog_sel(analog_sel), .mclr_en(mclr_en),
        .dir_q(dir_q), .rdata(bus_rdata)
    );

    // Drive the pads: latch value, and driver enabled where direction is 0.
    assign pad_dout = latch_q;
    assign pad_oe   = ~dir_q;

    assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == '0);
    assert_oe_matches_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> pad_oe == ~bus_rdata[OUT_W-1:0]);
    assert_dout_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_sel) |=> pad_dout == $past(bus_wdata[OUT_W-1:0]));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_dout) && $stable(pad_oe)));
endmodule

// File: tb/gpio4_port_tb.sv
`timescale 1ns/100ps
// Directed bench for gpio4_port: one task per scenario, each checking itself.
module gpio4_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in;
    logic [3:0] analog_sel;
    logic       mclr_en;
    logic [2:0] pad_dout;
    logic [2:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio4_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .analog_sel(analog_sel), .mclr_en(mclr_en),
        .pad_dout(pad_dout), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] d);
        bus_sel = sel;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle_pins(input logic [3:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
        pin_in = 4'h0; analog_sel = 4'h0; mclr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        bus_read(1'b1, r);
        check("R1 dir after reset", r, 8'h0F);
        check("R1 oe after reset", {5'b0, pad_oe}, 8'h00);
        check("R1 dout after reset", {5'b0, pad_dout}, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] r;
        bus_write(1'b1, 8'hF0);
        bus_read(1'b1, r);
        check("R2 dir all out", r, 8'h08);
        check("R2 oe all on", {5'b0, pad_oe}, 8'h07);
        check("R8 pin3 dir stays 1", {7'b0, r[3]}, 8'h01);
        bus_write(1'b1, 8'hA5);
        bus_read(1'b1, r);
        check("R2 dir mixed", r, 8'h0D);
        check("R2 oe mixed", {5'b0, pad_oe}, 8'h02);
    endtask

    task automatic t_latch();
        logic [7:0] r;
        bus_write(1'b0, 8'hFA);
        check("R3 dout from write", {5'b0, pad_dout}, 8'h02);
        bus_read(1'b1, r);
        check("R9 dir unchanged by data write", r, 8'h0D);
        bus_write(1'b1, 8'h00);
        check("R9 latch unchanged by dir write", {5'b0, pad_dout}, 8'h02);
        repeat (3) @(negedge clk);
        check("R9 idle holds latch", {5'b0, pad_dout}, 8'h02);
        check("R9 idle holds oe", {5'b0, pad_oe}, 8'h07);
    endtask

    task automatic t_pin_read();
        logic [7:0] r;
        settle_pins(4'hC);
        bus_read(1'b0, r);
        check("R4 pins not latch", r, 8'h0C);
        @(negedge clk); pin_in = 4'h3;
        @(posedge clk); @(negedge clk);
        bus_read(1'b0, r);
        check("R4 old level after one edge", r, 8'h0C);
        @(negedge clk);
        bus_read(1'b0, r);
        check("R4 new level after two edges", r, 8'h03);
    endtask

    task automatic t_analog();
        logic [7:0] r;
        settle_pins(4'hF);
        analog_sel = 4'h5;
        bus_read(1'b0, r);
        check("R5 analog pins read 0", r, 8'h0A);
        check("R5 driver unaffected", {5'b0, pad_oe}, 8'h07);
        analog_sel = 4'h8;
        bus_read(1'b0, r);
        check("R5 analog pin3", r, 8'h07);
        analog_sel = 4'h0;
    endtask

    task automatic t_mclr();
        logic [7:0] r;
        settle_pins(4'hF);
        mclr_en = 1'b1;
        bus_read(1'b0, r);
        check("R6 mclr hides pin3", r, 8'h07);
        mclr_en = 1'b0;
        bus_read(1'b0, r);
        check("R6 mclr off", r, 8'h0F);
    endtask

    task automatic bit_op(input int idx, input bit set_it, input logic [3:0] pins,
                          input logic [2:0] exp_latch);
        logic [7:0] r;
        settle_pins(pins);
        bus_read(1'b0, r);
        if (set_it) r[idx] = 1'b1; else r[idx] = 1'b0;
        bus_write(1'b0, r);
        check("R7 rmw latch", {5'b0, pad_dout}, {5'b0, exp_latch});
    endtask

    task automatic t_rmw();
        bus_write(1'b0, 8'h00);
        bit_op(1, 1'b1, 4'h5, 3'b111);
        bus_write(1'b0, 8'h07);
        bit_op(0, 1'b0, 4'hB, 3'b010);
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_direction();
        t_latch();
        t_pin_read();
        t_analog();
        t_mclr();
        t_rmw();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule